// File: doc/BRIEF.md
# Pixel Depth Reducer with Gain

This block turns a stream of 10-bit pixel samples into 8-bit pixels, one per clock, for a display path or a store that works in bytes. A 2-bit mode input chooses among three linear gains and one compressive curve. Each linear gain selects an 8-bit window of the 10-bit sample. At the higher gains a pixel that has a set bit above its window is clipped to full scale, so it does not wrap around to a dark value. The compressive curve is piecewise linear. It gives the dark end of the range more output codes than the bright end.

The mode is taken only on the first valid pixel of a frame, so one frame never mixes two gains. The pixel, the valid strobe and the frame and line start flags all leave the block one clock after they enter. When valid is low, the pixel output keeps its last value.

Top module: `pix_depth_reducer`

## Requirements
- R1: While reset is active and on the first clock after it, `out_pix`, `out_valid`, `out_frame_start` and `out_line_start` are zero, and the mode in force is gain 1.
- R2: Mode code 2'b00 is gain 1, and the output pixel is input bits [9:2].
- R3: Mode code 2'b01 is gain 2. The output is input bits [8:1], or 8'hFF if input bit 9 is set.
- R4: Mode code 2'b10 is gain 4. The output is input bits [7:0], or 8'hFF if either input bit 9 or bit 8 is set.
- R5: Mode code 2'b11 is the compressive curve, and each output is rounded down. Inputs 0..127 give in/2. Inputs 128..255 give 64+(in-128)/4. Inputs 256..511 give 96+(in-256)/4. Inputs 512..1023 give 160+(in-512)/8. The output never exceeds 223.
- R6: `mode_sel` is captured only on a clock where `in_valid` and `in_frame_start` are both high, and it applies to that pixel and to every later pixel. A change of `mode_sel` at any other time has no effect on the output. This includes a frame start with valid low.
- R7: `out_valid`, `out_frame_start`, `out_line_start` and `out_pix` follow their inputs with a latency of exactly one clock.
- R8: On a clock where `in_valid` is low, `out_pix` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Gain or curve selection: 00 gain 1, 01 gain 2, 10 gain 4, 11 curve |
| in_valid | input | 1 | Input pixel is valid |
| in_frame_start | input | 1 | Marks the first pixel of a frame |
| in_line_start | input | 1 | Marks the first pixel of a line |
| in_pix | input | 10 | Input pixel sample |
| out_valid | output | 1 | Output pixel is valid |
| out_frame_start | output | 1 | Frame start flag, delayed one clock |
| out_line_start | output | 1 | Line start flag, delayed one clock |
| out_pix | output | 8 | Reduced 8-bit pixel |

## Verification
Two events can land on the same clock: a mode capture at a frame start, and the mapping of that same pixel. The bench opens every table vector with a frame-start pixel that carries a new mode. The result one clock later must already show the new mode, so a design that captures the mode one clock late gives the wrong value. The bench also changes `mode_sel` in the middle of a frame and on a frame start with valid low, and it expects the output to keep following the mode held before.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  localparam int PIX_IN_W  = 10;
  localparam int PIX_OUT_W = 8;
  localparam int DROP_W    = PIX_IN_W - PIX_OUT_W;

  typedef enum logic [1:0] {
    MODE_G1    = 2'b00,
    MODE_G2    = 2'b01,
    MODE_G4    = 2'b10,
    MODE_CURVE = 2'b11
  } pdr_mode_e;

  // Shift the window down by 'shift' bits and clip if any bit above it is set.
  function automatic logic [PIX_OUT_W-1:0] window_clip(
      input logic [PIX_IN_W-1:0] pix, input int shift);
    logic [PIX_IN_W-1:0] shifted;
    shifted = pix >> shift;
    if (shifted[PIX_IN_W-1:PIX_OUT_W] != '0) return '1;
    return shifted[PIX_OUT_W-1:0];
  endfunction

  // Four-segment compressive curve; every segment is continuous at its knee.
  function automatic logic [PIX_OUT_W-1:0] curve_map(input logic [PIX_IN_W-1:0] pix);
    logic [PIX_IN_W:0] acc;
    if (pix < 10'd128)      acc = {1'b0, pix >> 1};
    else if (pix < 10'd256) acc = 11'd64  + {1'b0, (pix - 10'd128) >> 2};
    else if (pix < 10'd512) acc = 11'd96  + {1'b0, (pix - 10'd256) >> 2};
    else                    acc = 11'd160 + {1'b0, (pix - 10'd512) >> 3};
    if (acc > 11'd255) return '1;
    return acc[PIX_OUT_W-1:0];
  endfunction
endpackage

// File: rtl/pdr_mode_hold.sv
module pdr_mode_hold
  import pdr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  logic [1:0] mode_sel,
  output pdr_mode_e eff_mode
);
  pdr_mode_e held_mode;

  always_ff @(posedge clk) begin
    if (!rst_n)       held_mode <= MODE_G1;
    else if (capture) held_mode <= pdr_mode_e'(mode_sel);
  end

  // The pixel that opens a frame already uses the newly selected mode.
  assign eff_mode = capture ? pdr_mode_e'(mode_sel) : held_mode;

  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(held_mode));
endmodule

// File: rtl/pdr_pix_map.sv
module pdr_pix_map
  import pdr_pkg::*;
(
  input  pdr_mode_e             mode,
  input  logic [PIX_IN_W-1:0]   pix_in,
  output logic [PIX_OUT_W-1:0]  pix_out
);
  localparam int NUM_LIN = 3;
  logic [PIX_OUT_W-1:0] lin_res [NUM_LIN];

  for (genvar g = 0; g < NUM_LIN; g++) begin : g_lin
    // gain 1 drops DROP_W bits, each doubling of gain drops one fewer
    assign lin_res[g] = window_clip(pix_in, DROP_W - g);
  end

  always_comb begin
    unique case (mode)
      MODE_G1:    pix_out = lin_res[0];
      MODE_G2:    pix_out = lin_res[1];
      MODE_G4:    pix_out = lin_res[2];
      default:    pix_out = curve_map(pix_in);
    endcase
  end
endmodule

// File: rtl/pdr_out_stage.sv
module pdr_out_stage
  import pdr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_fs,
  input  logic                 in_ls,
  input  logic [PIX_OUT_W-1:0] in_pix,
  output logic                 out_valid,
  output logic                 out_fs,
  output logic                 out_ls,
  output logic [PIX_OUT_W-1:0] out_pix
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fs    <= 1'b0;
      out_ls    <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      out_fs    <= in_fs;
      out_ls    <= in_ls;
      if (in_valid) out_pix <= in_pix;
    end
  end
endmodule

// File: rtl/pix_depth_reducer.sv
module pix_depth_reducer
  import pdr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_sel,
  input  logic                 in_valid,
  input  logic                 in_frame_start,
  input  logic                 in_line_start,
  input  logic [PIX_IN_W-1:0]  in_pix,
  output logic                 out_valid,
  output logic                 out_frame_start,
  output logic                 out_line_start,
  output logic [PIX_OUT_W-1:0] out_pix
);
  logic                 mode_capture;
  pdr_mode_e            eff_mode;
  logic [PIX_OUT_W-1:0] mapped_pix;

  assign mode_capture = in_valid & in_frame_start;

  pdr_mode_hold i_mode (
    .clk(clk), .rst_n(rst_n), .capture(mode_capture),
    .mode_sel(mode_sel), .eff_mode(eff_mode)
  );

  pdr_pix_map i_map (
    .mode(eff_mode), .pix_in(in_pix), .pix_out(mapped_pix)
  );

  pdr_out_stage i_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_fs(in_frame_start), .in_ls(in_line_start),
    .in_pix(mapped_pix),
    .out_valid(out_valid), .out_fs(out_frame_start), .out_ls(out_line_start),
    .out_pix(out_pix)
  );

  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_mode == MODE_G4 && in_pix[PIX_IN_W-1 -: DROP_W] != '0)
      |=> out_pix == 8'hFF);

  a_r5_curve_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_mode == MODE_CURVE) |=> out_pix <= 8'd223);

  a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)) &&
             (out_line_start == $past(in_line_start)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pix));
endmodule

// File: tb/test_pix_depth_reducer.sv
module test_pix_depth_reducer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       in_valid = 1'b0, in_frame_start = 1'b0, in_line_start = 1'b0;
  logic [9:0] in_pix = '0;
  logic       out_valid, out_frame_start, out_line_start;
  logic [7:0] out_pix;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pix_depth_reducer i_pix_depth_reducer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_frame_start(in_frame_start), .in_line_start(in_line_start), .in_pix(in_pix),
    .out_valid(out_valid), .out_frame_start(out_frame_start),
    .out_line_start(out_line_start), .out_pix(out_pix)
  );

  // {mode, input pixel, expected output}, expected values worked from the requirements
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {2'b00, 10'd1023, 8'd255}, {2'b00, 10'd4,   8'd1},   {2'b00, 10'd3,   8'd0},
    {2'b00, 10'd514,  8'd128},
    {2'b01, 10'd511,  8'd255}, {2'b01, 10'd512, 8'hFF},  {2'b01, 10'd300, 8'd150},
    {2'b01, 10'd1,    8'd0},
    {2'b10, 10'd255,  8'd255}, {2'b10, 10'd256, 8'hFF},  {2'b10, 10'd100, 8'd100},
    {2'b10, 10'd0,    8'd0},
    {2'b11, 10'd127,  8'd63},  {2'b11, 10'd128, 8'd64},  {2'b11, 10'd255, 8'd95},
    {2'b11, 10'd256,  8'd96},  {2'b11, 10'd511, 8'd159}, {2'b11, 10'd512, 8'd160},
    {2'b11, 10'd1023, 8'd223}, {2'b11, 10'd1000, 8'd221}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply inputs at a falling edge, then look at the outputs one falling edge later
  task automatic step(input logic [1:0] m, input logic v, input logic fs,
                      input logic ls, input logic [9:0] p);
    mode_sel = m; in_valid = v; in_frame_start = fs; in_line_start = ls; in_pix = p;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 out_pix in reset", out_pix, 0);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 out_frame_start in reset", out_frame_start, 0);
    rst_n = 1'b1;
    // R1: mode after reset is gain 1
    step(2'b11, 1'b1, 1'b0, 1'b0, 10'd400);
    check("R1 default gain 1", out_pix, 100);
    check("R7 out_valid one clock later", out_valid, 1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19:18], 1'b1, 1'b1, 1'b0, VEC[i][17:8]);
      check($sformatf("R2-R5 vector %0d (R2 R3 R4 R5)", i), out_pix, VEC[i][7:0]);
      check("R7 frame start delayed", out_frame_start, 1);
    end

    // R6: capture gain 4 on a frame start, then change mode_sel mid-frame
    step(2'b10, 1'b1, 1'b1, 1'b0, 10'd100);
    check("R6 capture gain 4", out_pix, 100);
    step(2'b00, 1'b1, 1'b0, 1'b1, 10'd100);
    check("R6 mid-frame change ignored", out_pix, 100);
    check("R7 line start delayed", out_line_start, 1);
    check("R7 frame start low", out_frame_start, 0);
    // R6: frame start with valid low does not capture
    step(2'b00, 1'b0, 1'b1, 1'b0, 10'd60);
    check("R8 hold while invalid", out_pix, 100);
    check("R7 valid low delayed", out_valid, 0);
    check("R7 frame start passes with valid low", out_frame_start, 1);
    step(2'b00, 1'b1, 1'b0, 1'b0, 10'd60);
    check("R6 invalid frame start ignored", out_pix, 60);
    // R8: input changes while invalid do not reach the output
    step(2'b00, 1'b0, 1'b0, 1'b0, 10'd1023);
    check("R8 hold value", out_pix, 60);
    step(2'b00, 1'b1, 1'b1, 1'b0, 10'd100);
    check("R6 new frame gain 1", out_pix, 25);
    // R3: boundary at the top of the gain 2 window
    step(2'b01, 1'b1, 1'b1, 1'b0, 10'd510);
    check("R3 top of window", out_pix, 255);
    // R4: bit 8 alone saturates gain 4
    step(2'b10, 1'b1, 1'b1, 1'b0, 10'd300);
    check("R4 bit 8 saturates", out_pix, 255);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule